// File: doc/BRIEF.md
# Cell Polling and Voltage-Fault Controller

This block runs the periodic threshold checks of a three-cell series stack. It uses one shared comparator, which it time-multiplexes over a fixed schedule of cell and limit pairs. From the comparator results it drives the enables of the charge switch and the discharge switch. A tick prescaler on the single clock produces all of its intervals.

**Polling schedule.** Each polling period begins with a sampling window. The first six ticks of the window are slots. In each slot the block selects one cell and one limit, and it samples the comparator result on the last clock of the slot.

**Overvoltage.** Overvoltage detections are counted per cell. A latched cell switches its comparator to a hysteresis level. That cell is then released only by a sample below that level.

**Undervoltage.** Two successive undervoltage detections raise an active-low fault flag. A programmable number of ticks later the block removes the discharge enable and goes to sleep. In sleep, polling and balancing stop until a charger is detected.

**Side functions.** The block also honours two active-low inhibit inputs and a charge-interrupt mode. A test reset holds all state cleared and forces both enables on.

Top module: `cell_poll_ctrl`

## Requirements
- R1: After `rst` or `test_rst` is released, the sampling window is open at once: `sel_valid`=1, `sel_cell`=0 and `sel_uv`=0 on the first clock. The flags are clear, and `chg_en`=`dsg_en`=1 unless an inhibit input is low.
- R2: Tick k of a period (k = 0..5) is a slot.
  - It has `sel_valid`=1.
  - `sel_cell` = k mod 3, with the encoding 0, 1, 2 for the lowest, middle and top cell.
  - `sel_uv` = 0 for an overvoltage test (k < 3) and 1 for an undervoltage test (k >= 3).
  - All other ticks have `sel_valid`=0 with `sel_cell`=0 and `sel_uv`=0.
  - A period lasts PERIOD_TICKS ticks of TICK_DIV clocks each.
- R3: `cmp_hit` is sampled on the last clock of a slot.
  - With `ov_two_sel`=0, one overvoltage hit latches that cell.
  - With `ov_two_sel`=1, two hits in successive periods are needed.
  - A miss clears that cell's count.
  - `chg_en` is 0 while any cell is latched.
- R4: While a cell is latched, `hyst_en` is 1 during that cell's overvoltage slot. A sample of 0 in that slot releases the latch.
- R5: When `chg_inh_n`=0, `chg_en` is forced to 0. When `dsg_inh_n`=0, `dsg_en` is forced to 0. Neither applies in sleep.
- R6: A second successive undervoltage hit on a cell drives `uv_fault_n` to 0 from the next clock. A miss clears that cell's count. The flag stays set until wake-up.
- R7: UV_DLY_TICKS ticks after the flag is set, `sleep` rises and `dsg_en` falls.
- R8: In sleep, `sel_valid`, `hyst_en`, `chg_intr` and `bal_en` are 0, and the inhibit inputs have no effect. `charger_present`=1 ends sleep on the next clock, clears `uv_fault_n` back to 1 and restarts the period at tick 0.
- R9: `chg_intr` = `chg_mode_sel` during ticks 0..WIN_TICKS-1 of each period outside sleep, and 0 otherwise.
- R10: `bal_en[i]` is 1 for each latched cell i, except that it is 000 when all three cells are latched.
- R11: While `test_rst` is 1, `chg_en` and `dsg_en` are 1 regardless of any other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_rst | input | 1 | Test reset: clears state, forces both enables on |
| cmp_hit | input | 1 | Shared comparator result for the selected cell and limit |
| ov_two_sel | input | 1 | 1: two successive overvoltage hits needed to latch |
| chg_mode_sel | input | 1 | 1: interrupt charging during each window |
| charger_present | input | 1 | Charger detected; wakes the block from sleep |
| chg_inh_n | input | 1 | Active-low charge inhibit |
| dsg_inh_n | input | 1 | Active-low discharge inhibit |
| sel_valid | output | 1 | A slot is active |
| sel_cell | output | 2 | Cell under test (0..2) |
| sel_uv | output | 1 | 0 overvoltage test, 1 undervoltage test |
| hyst_en | output | 1 | Use the hysteresis level for this sample |
| chg_intr | output | 1 | Charge interrupt during the window |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| uv_fault_n | output | 1 | Active-low undervoltage fault flag |
| bal_en | output | 3 | Per-cell balancing enables |
| sleep | output | 1 | Sleep state |

## Verification
The bench builds the block with TICK_DIV=3, WIN_TICKS=8, PERIOD_TICKS=12 and UV_DLY_TICKS=5. A polling period is then 36 clocks, and the undervoltage disconnect follows the fault flag by 15 clocks.

With these values, tens of complete periods fit into a short run. That brings within reach:
- single-hit and two-hit latching;
- release through the hysteresis level;
- the full flag-to-sleep timeout;
- wake-up and a test-reset restart.

Each of these is checked against a behavioural model on every clock.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    localparam int NCELL = 3;
    localparam int NSLOT = 2 * NCELL;

    typedef struct packed {
        logic       ov_lat;
        logic       ov_seen;
        logic [1:0] uv_cnt;
    } cell_st_t;
endpackage

// File: rtl/cpc_timebase.sv
module cpc_timebase #(
    parameter int TICK_DIV     = 1000,
    parameter int PERIOD_TICKS = 4000,
    parameter int POS_W        = $clog2(PERIOD_TICKS + 1)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    output logic             tick,
    output logic [POS_W-1:0] pos
);
    localparam int CNT_W = $clog2(TICK_DIV + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(PERIOD_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [POS_W-1:0] pos;
    } tb_st_t;

    tb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == CNT_LAST);
        if (clr) begin
            st_d = '0;
        end else if (run) begin
            if (tick) begin
                st_d.cnt = '0;
                st_d.pos = (st_q.pos == POS_LAST) ? '0 : st_q.pos + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pos = st_q.pos;
endmodule

// File: rtl/cpc_cell_track.sv
module cpc_cell_track
    import cpc_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic uv_clr,
    input  logic ov_smp,
    input  logic uv_smp,
    input  logic hit,
    input  logic need_two,
    output logic ov_lat,
    output logic uv_trip
);
    cell_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        uv_trip = 1'b0;
        if (ov_smp) begin
            if (st_q.ov_lat) begin
                // hysteresis sample: a miss releases the latch
                if (!hit) begin
                    st_d.ov_lat  = 1'b0;
                    st_d.ov_seen = 1'b0;
                end
            end else if (hit) begin
                if (!need_two || st_q.ov_seen) begin
                    st_d.ov_lat  = 1'b1;
                    st_d.ov_seen = 1'b0;
                end else begin
                    st_d.ov_seen = 1'b1;
                end
            end else begin
                st_d.ov_seen = 1'b0;
            end
        end
        if (uv_smp) begin
            if (hit) begin
                uv_trip     = (st_q.uv_cnt == 2'd1);
                st_d.uv_cnt = (st_q.uv_cnt == 2'd0) ? 2'd1 : 2'd2;
            end else begin
                st_d.uv_cnt = 2'd0;
            end
        end
        if (uv_clr) st_d.uv_cnt = 2'd0;
        if (clr)    st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ov_lat = st_q.ov_lat;
endmodule

// File: rtl/cell_poll_ctrl.sv
module cell_poll_ctrl
    import cpc_pkg::*;
#(
    parameter int TICK_DIV     = 1000,
    parameter int WIN_TICKS    = 16,
    parameter int PERIOD_TICKS = 4000,
    parameter int UV_DLY_TICKS = 64000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       test_rst,
    input  logic       cmp_hit,
    input  logic       ov_two_sel,
    input  logic       chg_mode_sel,
    input  logic       charger_present,
    input  logic       chg_inh_n,
    input  logic       dsg_inh_n,
    output logic       sel_valid,
    output logic [1:0] sel_cell,
    output logic       sel_uv,
    output logic       hyst_en,
    output logic       chg_intr,
    output logic       chg_en,
    output logic       dsg_en,
    output logic       uv_fault_n,
    output logic [2:0] bal_en,
    output logic       sleep
);
    localparam int POS_W = $clog2(PERIOD_TICKS + 1);
    localparam int DLY_W = $clog2(UV_DLY_TICKS + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(UV_DLY_TICKS - 1);

    typedef struct packed {
        logic             uv_flag;
        logic             sleep;
        logic [DLY_W-1:0] dly;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             hold, wake, tick;
    logic [POS_W-1:0] pos;
    logic [NCELL-1:0] ov_lat, uv_trip;
    logic [3:0]       ov_lat_x;

    assign hold = rst | test_rst;
    assign wake = st_q.sleep & charger_present;

    cpc_timebase #(
        .TICK_DIV    (TICK_DIV),
        .PERIOD_TICKS(PERIOD_TICKS),
        .POS_W       (POS_W)
    ) u_tb (
        .clk (clk),
        .clr (hold | wake),
        .run (!st_q.sleep),
        .tick(tick),
        .pos (pos)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        cpc_cell_track u_trk (
            .clk     (clk),
            .clr     (hold),
            .uv_clr  (wake),
            .ov_smp  (tick && (pos == POS_W'(i))),
            .uv_smp  (tick && (pos == POS_W'(i + NCELL))),
            .hit     (cmp_hit),
            .need_two(ov_two_sel),
            .ov_lat  (ov_lat[i]),
            .uv_trip (uv_trip[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (tick && st_q.uv_flag) begin
            if (st_q.dly == DLY_LAST) st_d.sleep = 1'b1;
            else                      st_d.dly   = st_q.dly + 1'b1;
        end
        if (|uv_trip) st_d.uv_flag = 1'b1;
        if (wake) begin
            st_d.sleep   = 1'b0;
            st_d.uv_flag = 1'b0;
            st_d.dly     = '0;
        end
        if (hold) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // slot decode
    always_comb begin
        sel_valid = 1'b0;
        sel_cell  = 2'd0;
        sel_uv    = 1'b0;
        if (!st_q.sleep) begin
            if (pos < POS_W'(NCELL)) begin
                sel_valid = 1'b1;
                sel_cell  = 2'(pos);
            end else if (pos < POS_W'(NSLOT)) begin
                sel_valid = 1'b1;
                sel_uv    = 1'b1;
                sel_cell  = 2'(pos - POS_W'(NCELL));
            end
        end
    end

    assign ov_lat_x   = {1'b0, ov_lat};
    assign hyst_en    = sel_valid && !sel_uv && ov_lat_x[sel_cell];
    assign chg_intr   = chg_mode_sel && !st_q.sleep && (pos < POS_W'(WIN_TICKS));
    assign chg_en     = test_rst | (~(|ov_lat) & (chg_inh_n | st_q.sleep));
    assign dsg_en     = test_rst | (~st_q.sleep & dsg_inh_n);
    assign uv_fault_n = ~st_q.uv_flag;
    assign bal_en     = (st_q.sleep || (&ov_lat)) ? '0 : ov_lat;
    assign sleep      = st_q.sleep;
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker (
    input logic       clk,
    input logic       rst,
    input logic       test_rst,
    input logic       charger_present,
    input logic       chg_mode_sel,
    input logic       sel_valid,
    input logic [1:0] sel_cell,
    input logic       sel_uv,
    input logic       hyst_en,
    input logic       chg_intr,
    input logic       chg_en,
    input logic       dsg_en,
    input logic       uv_fault_n,
    input logic [2:0] bal_en,
    input logic       sleep
);
    p_sel_cell_r2: assert property (@(posedge clk) disable iff (rst || test_rst)
        sel_valid |-> sel_cell != 2'd3);

    p_hyst_slot_r4: assert property (@(posedge clk) disable iff (rst || test_rst)
        hyst_en |-> sel_valid && !sel_uv);

    p_uv_hold_r6: assert property (@(posedge clk) disable iff (rst || test_rst)
        (!uv_fault_n && !(sleep && charger_present)) |=> !uv_fault_n);

    p_sleep_entry_r7: assert property (@(posedge clk) disable iff (rst || test_rst)
        $rose(sleep) |-> !uv_fault_n);

    p_sleep_dsg_r7: assert property (@(posedge clk) disable iff (rst || test_rst)
        sleep |-> !dsg_en);

    p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (rst || test_rst)
        sleep |-> !sel_valid && !chg_intr && !hyst_en && bal_en == 3'b000);

    p_wake_r8: assert property (@(posedge clk) disable iff (rst || test_rst)
        (sleep && charger_present) |=> !sleep && uv_fault_n);

    p_intr_mode_r9: assert property (@(posedge clk) disable iff (rst || test_rst)
        chg_intr |-> chg_mode_sel);

    p_bal_all_r10: assert property (@(posedge clk) disable iff (rst || test_rst)
        bal_en != 3'b111);

    p_test_on_r11: assert property (@(posedge clk) disable iff (rst)
        test_rst |-> chg_en && dsg_en);
endmodule

bind cell_poll_ctrl cpc_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .test_rst       (test_rst),
    .charger_present(charger_present),
    .chg_mode_sel   (chg_mode_sel),
    .sel_valid      (sel_valid),
    .sel_cell       (sel_cell),
    .sel_uv         (sel_uv),
    .hyst_en        (hyst_en),
    .chg_intr       (chg_intr),
    .chg_en         (chg_en),
    .dsg_en         (dsg_en),
    .uv_fault_n     (uv_fault_n),
    .bal_en         (bal_en),
    .sleep          (sleep)
);

// File: tb/cell_poll_ctrl_test.sv
`timescale 1ns/1ps
module cell_poll_ctrl_test;
    localparam int DIV = 3;
    localparam int WIN = 8;
    localparam int PER = 12;
    localparam int UVD = 5;
    localparam int PCLK = DIV * PER;

    logic clk = 1'b0;
    logic rst = 1'b1, test_rst = 1'b0, ov_two_sel = 1'b0, chg_mode_sel = 1'b1;
    logic charger_present = 1'b0, chg_inh_n = 1'b1, dsg_inh_n = 1'b1;
    logic cmp_hit;
    logic sel_valid, sel_uv, hyst_en, chg_intr, chg_en, dsg_en, uv_fault_n, sleep;
    logic [1:0] sel_cell;
    logic [2:0] bal_en;

    // cell condition levels (bit 3 unused)
    logic [3:0] lv_ov = '0, lv_hy = '0, lv_uv = '0;

    int total = 0, bad = 0, cycles = 0;
    bit cmp_on = 0, done = 0;

    always #2 clk = ~clk;

    assign cmp_hit = sel_uv ? lv_uv[sel_cell] : (hyst_en ? lv_hy[sel_cell] : lv_ov[sel_cell]);

    cell_poll_ctrl #(.TICK_DIV(DIV), .WIN_TICKS(WIN), .PERIOD_TICKS(PER), .UV_DLY_TICKS(UVD)) uut (
        .clk(clk), .rst(rst), .test_rst(test_rst), .cmp_hit(cmp_hit), .ov_two_sel(ov_two_sel),
        .chg_mode_sel(chg_mode_sel), .charger_present(charger_present), .chg_inh_n(chg_inh_n),
        .dsg_inh_n(dsg_inh_n), .sel_valid(sel_valid), .sel_cell(sel_cell), .sel_uv(sel_uv),
        .hyst_en(hyst_en), .chg_intr(chg_intr), .chg_en(chg_en), .dsg_en(dsg_en),
        .uv_fault_n(uv_fault_n), .bal_en(bal_en), .sleep(sleep));

    // behavioural reference model
    int m_cnt = 0, m_pos = 0, m_dly = 0, c = 0;
    bit m_flag = 0, m_slp = 0;
    bit m_ovl[3], m_seen[3];
    int m_uvc[3];

    always @(posedge clk) begin
        if (rst || test_rst) begin
            m_cnt = 0; m_pos = 0; m_dly = 0; m_flag = 0; m_slp = 0;
            for (int i = 0; i < 3; i++) begin m_ovl[i] = 0; m_seen[i] = 0; m_uvc[i] = 0; end
        end else if (m_slp) begin
            if (charger_present) begin
                m_slp = 0; m_flag = 0; m_dly = 0; m_cnt = 0; m_pos = 0;
                for (int i = 0; i < 3; i++) m_uvc[i] = 0;
            end
        end else if (m_cnt == DIV - 1) begin
            if (m_flag) begin
                if (m_dly == UVD - 1) m_slp = 1; else m_dly++;
            end
            if (m_pos < 3) begin
                c = m_pos;
                if (m_ovl[c]) begin
                    if (!lv_hy[c]) begin m_ovl[c] = 0; m_seen[c] = 0; end
                end else if (lv_ov[c]) begin
                    if (!ov_two_sel || m_seen[c]) begin m_ovl[c] = 1; m_seen[c] = 0; end
                    else m_seen[c] = 1;
                end else m_seen[c] = 0;
            end else if (m_pos < 6) begin
                c = m_pos - 3;
                if (lv_uv[c]) begin
                    if (m_uvc[c] == 1) m_flag = 1;
                    m_uvc[c] = (m_uvc[c] == 0) ? 1 : 2;
                end else m_uvc[c] = 0;
            end
            m_pos = (m_pos == PER - 1) ? 0 : m_pos + 1;
            m_cnt = 0;
        end else begin
            m_cnt++;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            automatic bit v = !m_slp && m_pos < 6;
            automatic int ec = v ? (m_pos < 3 ? m_pos : m_pos - 3) : 0;
            automatic bit eu = v && m_pos >= 3;
            automatic bit anyl = m_ovl[0] | m_ovl[1] | m_ovl[2];
            automatic bit alll = m_ovl[0] & m_ovl[1] & m_ovl[2];
            automatic int eb = (m_slp || alll) ? 0 : {m_ovl[2], m_ovl[1], m_ovl[0]};
            chk("R2", "sel_valid", sel_valid, v);
            chk("R2", "sel_cell", sel_cell, ec);
            chk("R2", "sel_uv", sel_uv, eu);
            chk("R4", "hyst_en", hyst_en, v && !eu && m_ovl[ec]);
            chk("R9", "chg_intr", chg_intr, chg_mode_sel && !m_slp && m_pos < WIN);
            chk("R3", "chg_en", chg_en, test_rst || (!anyl && (chg_inh_n || m_slp)));
            chk("R5", "dsg_en", dsg_en, test_rst || (!m_slp && dsg_inh_n));
            chk("R6", "uv_fault_n", uv_fault_n, !m_flag);
            chk("R7", "sleep", sleep, m_slp);
            chk("R10", "bal_en", bal_en, eb);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        step(3);
        cmp_on = 1;
        rst = 0;
        #0;
        // R1 reset state and immediate window
        chk("R1", "sel_valid", sel_valid, 1);
        chk("R1", "sel_cell", sel_cell, 0);
        chk("R1", "chg_en", chg_en, 1);
        chk("R1", "dsg_en", dsg_en, 1);
        chk("R1", "uv_fault_n", uv_fault_n, 1);
        chk("R9", "chg_intr", chg_intr, 1);
        step(2 * PCLK);

        // R3 single-hit latch, R4 hysteresis release, R10 balancing
        lv_ov[1] = 1; lv_hy[1] = 1;
        step(PCLK);
        chk("R3", "chg_en one hit", chg_en, 0);
        chk("R10", "bal_en", bal_en, 3'b010);
        lv_ov[1] = 0;
        step(PCLK);
        chk("R4", "chg_en above hyst", chg_en, 0);
        lv_hy[1] = 0;
        step(PCLK);
        chk("R4", "chg_en released", chg_en, 1);

        // R3 two successive hits needed
        ov_two_sel = 1; chg_mode_sel = 0;
        lv_ov[0] = 1; lv_hy[0] = 1;
        step(PCLK);
        lv_ov[0] = 0;
        step(PCLK);
        chk("R3", "chg_en single hit ignored", chg_en, 1);
        lv_ov[0] = 1;
        step(2 * PCLK);
        chk("R3", "chg_en two hits", chg_en, 0);
        lv_ov[0] = 0; lv_hy[0] = 0;
        step(PCLK);
        chk("R4", "chg_en released", chg_en, 1);

        // R10 all cells latched
        ov_two_sel = 0;
        lv_ov = 4'b0111; lv_hy = 4'b0111;
        step(PCLK);
        chk("R10", "bal_en all", bal_en, 0);
        chk("R3", "chg_en all", chg_en, 0);
        lv_ov = '0; lv_hy = '0;
        step(PCLK);
        chk("R4", "chg_en cleared", chg_en, 1);

        // R5 inhibits
        chg_inh_n = 0; dsg_inh_n = 0;
        step(2);
        chk("R5", "chg_en inhibited", chg_en, 0);
        chk("R5", "dsg_en inhibited", dsg_en, 0);
        chg_inh_n = 1; dsg_inh_n = 1;
        step(2);

        // R6 one undervoltage hit then a miss: no fault
        chg_mode_sel = 1;
        lv_uv[2] = 1;
        step(PCLK);
        lv_uv[2] = 0;
        step(2 * PCLK);
        chk("R6", "uv_fault_n single", uv_fault_n, 1);
        lv_uv[2] = 1;
        while (uv_fault_n && !done) step(1);
        chk("R6", "dsg_en kept", dsg_en, 1);
        chk("R7", "sleep early", sleep, 0);
        step(DIV * UVD - 1);
        chk("R7", "sleep before delay", sleep, 0);
        step(1);
        chk("R7", "sleep after delay", sleep, 1);
        chk("R7", "dsg_en off", dsg_en, 0);

        // R8 sleep behaviour
        lv_uv = '0;
        chg_inh_n = 0; dsg_inh_n = 0;
        step(PCLK + 4);
        chk("R8", "chg_en inhibit ignored", chg_en, 1);
        chk("R8", "sel_valid", sel_valid, 0);
        chk("R8", "chg_intr", chg_intr, 0);
        chg_inh_n = 1; dsg_inh_n = 1;
        charger_present = 1;
        step(1);
        charger_present = 0;
        chk("R8", "sleep wake", sleep, 0);
        chk("R8", "uv_fault_n wake", uv_fault_n, 1);
        chk("R8", "sel_valid restart", sel_valid, 1);
        chk("R8", "sel_cell restart", sel_cell, 0);
        step(2 * PCLK);

        // R11 test reset
        lv_ov[2] = 1; lv_hy[2] = 1;
        step(PCLK);
        chk("R3", "chg_en latched", chg_en, 0);
        test_rst = 1; chg_inh_n = 0; dsg_inh_n = 0;
        step(3);
        chk("R11", "chg_en test", chg_en, 1);
        chk("R11", "dsg_en test", dsg_en, 1);
        test_rst = 0; chg_inh_n = 1; dsg_inh_n = 1;
        #0;
        chk("R1", "sel_valid after test", sel_valid, 1);
        chk("R1", "chg_en after test", chg_en, 1);
        lv_ov = '0; lv_hy = '0;
        step(2 * PCLK);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule